// File: doc/BRIEF.md
# Row Nearest-Feature Distance Scanner

This block takes one image row at a time and works out, for every column, how far the nearest feature pixel in that same row lies horizontally and which label that feature carries. Pixels arrive on a valid/ready stream, one per accepted cycle. Each pixel is either a reserved background code or a feature carrying a small label. The block stores the row internally, fills in running distances with a left-to-right sweep, and then refines them with a right-to-left sweep. The result is, at each column, the closer of the two candidates. Results then stream out left to right as packed label/distance words.

Combining rows into a true two-dimensional Euclidean distance is left to a later stage. This block only resolves the horizontal component. A row with no feature at all produces distances that all exceed the row width, so the later stage can recognise them as invalid. The running distance starts every sweep at `ROW_W + IMG_H` and saturates at the top of its field instead of wrapping.

Top module: `row_dist_scan`

## Requirements
- R1: An input pixel equal to all ones (16'hFFFF) is background. Any other value is a feature whose label is its lowest 4 bits, `in_pix[3:0]`.
- R2: For each sweep, the running distance starts at `ROW_W+IMG_H` and the running label at 0. A feature pixel sets the distance to 0 and the label to its own. A background pixel adds 1 to the distance and keeps the label.
- R3: The distance output for each column is the smaller of the left-to-right and the right-to-left sweep values, together with that sweep's label. When the two are equal, the left-to-right result is kept.
- R4: `out_data[15:12]` carries the label and `out_data[11:0]` carries the distance.
- R5: In a row without any feature pixel, every output distance is greater than `ROW_W` and every label is 0.
- R6: The running distance saturates at 4095 and never wraps back to small values.
- R7: `in_ready` is high while the row is being loaded. `out_valid`, `out_data` and `out_last` stay unchanged while `out_ready` is low. `out_last` is high exactly on the output of column `ROW_W-1`.
- R8: An accepted pixel with `in_sof` high starts a new row at column 0. Pixels already accepted for the row it interrupts have no effect on any output.
- R9: Loading and output never overlap (`in_ready` and `out_valid` are never both high). After the handshake of the last output of a row, `in_ready` is high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| in_pix | input | 16 | Pixel: all ones is background, otherwise a feature with its label in the low bits |
| in_sof | input | 1 | Pixel is the first of a row |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 16 | Label in bits 15:12, distance in bits 11:0 |
| out_last | output | 1 | Word belongs to the final column of the row |

## Verification
The bench feeds rows against a behavioural model of both sweeps. The rows are: a lone feature in mid-row, which checks growth in both directions; features at both ends, which check that the reverse sweep overrides; two features with a column exactly between them, which checks the tie rule; and an empty row whose start value lies near the top of the field, which checks both the invalid marking and saturation. Pixels with high bits set, the zero label and the code one below background check how inputs are decoded. An interrupted row followed by a full one checks the restart flag. Irregular `out_ready` stalls and gaps in the input stream check the handshakes and the position of `out_last`.

// File: rtl/row_dist_scan.sv
module row_dist_scan #(
  parameter int ROW_W  = 32,
  parameter int IMG_H  = 24,
  parameter int LBL_W  = 4,
  parameter int DIST_W = 12,
  parameter int PIX_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PIX_W-1:0]        in_pix,
  input  logic                    in_sof,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LBL_W+DIST_W-1:0] out_data,
  output logic                    out_last
);
  localparam int CW = (ROW_W > 1) ? $clog2(ROW_W) : 1;
  localparam int WW = LBL_W + DIST_W;
  localparam logic [DIST_W-1:0] DMAX  = {DIST_W{1'b1}};
  localparam logic [DIST_W-1:0] DINIT = DIST_W'(ROW_W + IMG_H);
  localparam logic [CW-1:0]     CLAST = CW'(ROW_W - 1);

  typedef enum logic [1:0] {S_LOAD, S_REV, S_OUT} phase_t;

  phase_t              phase;
  logic [CW-1:0]       col;
  logic [DIST_W-1:0]   run_d;
  logic [LBL_W-1:0]    run_l;
  logic [WW-1:0]       mem [ROW_W];

  function automatic logic [DIST_W-1:0] bump(input logic [DIST_W-1:0] d);
    return (d == DMAX) ? d : d + 1'b1;
  endfunction

  // forward sweep, evaluated on the incoming pixel
  logic              take, in_feat, f_start;
  logic [CW-1:0]     wcol;
  logic [DIST_W-1:0] f_base_d, f_d;
  logic [LBL_W-1:0]  f_base_l, f_l;

  assign take     = in_valid && in_ready;
  assign in_feat  = ~&in_pix;
  assign wcol     = in_sof ? '0 : col;
  assign f_start  = in_sof || (col == '0);
  assign f_base_d = f_start ? DINIT : run_d;
  assign f_base_l = f_start ? '0 : run_l;
  assign f_d      = in_feat ? '0 : bump(f_base_d);
  assign f_l      = in_feat ? in_pix[LBL_W-1:0] : f_base_l;

  // reverse sweep, merged with the stored forward entry
  logic [WW-1:0]     fw_word;
  logic [DIST_W-1:0] fw_d, r_base_d, r_d;
  logic [LBL_W-1:0]  fw_l, r_base_l, r_l;
  logic              r_start, fw_feat, use_rev;

  assign fw_word  = mem[col];
  assign fw_d     = fw_word[DIST_W-1:0];
  assign fw_l     = fw_word[WW-1:DIST_W];
  assign fw_feat  = (fw_d == '0);
  assign r_start  = (col == CLAST);
  assign r_base_d = r_start ? DINIT : run_d;
  assign r_base_l = r_start ? '0 : run_l;
  assign r_d      = fw_feat ? '0 : bump(r_base_d);
  assign r_l      = fw_feat ? fw_l : r_base_l;
  assign use_rev  = r_d < fw_d;

  assign in_ready  = (phase == S_LOAD);
  assign out_valid = (phase == S_OUT);
  assign out_data  = fw_word;
  assign out_last  = out_valid && (col == CLAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= S_LOAD;
      col   <= '0;
      run_d <= '0;
      run_l <= '0;
    end else begin
      case (phase)
        S_LOAD: if (take) begin
          run_d <= f_d;
          run_l <= f_l;
          if (wcol == CLAST) begin
            phase <= S_REV;
            col   <= CLAST;
          end else begin
            col <= wcol + 1'b1;
          end
        end
        S_REV: begin
          run_d <= r_d;
          run_l <= r_l;
          if (col == '0) phase <= S_OUT;
          else           col   <= col - 1'b1;
        end
        default: if (out_ready) begin
          if (col == CLAST) begin
            phase <= S_LOAD;
            col   <= '0;
          end else begin
            col <= col + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (phase == S_LOAD && take)
      mem[wcol] <= {f_l, f_d};
    else if (phase == S_REV && use_rev)
      mem[col] <= {r_l, r_d};
  end
endmodule

module row_dist_scan_chk #(
  parameter int ROW_W  = 32,
  parameter int IMG_H  = 24,
  parameter int LBL_W  = 4,
  parameter int DIST_W = 12,
  parameter int PIX_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [PIX_W-1:0]        in_pix,
  input logic                    in_sof,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LBL_W+DIST_W-1:0] out_data,
  input logic                    out_last
);
  localparam int CW = $clog2(ROW_W) + 1;
  logic [CW-1:0] ocnt;
  logic          row_feat;
  logic          feat;
  assign feat = ~&in_pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocnt     <= '0;
      row_feat <= 1'b0;
    end else begin
      if (in_valid && in_ready)
        row_feat <= in_sof ? feat : (row_feat | feat);
      if (out_valid && out_ready) begin
        if (out_last) begin
          ocnt     <= '0;
          row_feat <= 1'b0;
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end

  p_phase_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  p_last_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (ocnt == CW'(ROW_W - 1))));

  p_empty_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !row_feat |-> (out_data[DIST_W-1:0] > DIST_W'(ROW_W)) &&
                               (out_data[LBL_W+DIST_W-1:DIST_W] == '0));
endmodule

bind row_dist_scan row_dist_scan_chk #(
  .ROW_W(ROW_W), .IMG_H(IMG_H), .LBL_W(LBL_W), .DIST_W(DIST_W), .PIX_W(PIX_W)
) u_chk (.*);

// File: tb/row_dist_scan_bench.sv
`timescale 1ns/1ps
module row_dist_scan_bench;
  localparam int W  = 16;
  localparam int H  = 4070;
  localparam logic [15:0] BG = 16'hFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_pix = '0;
  logic        in_sof = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_last;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int seed   = 7;

  logic [15:0] exp_q[$];
  bit          last_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  row_dist_scan #(.ROW_W(W), .IMG_H(H)) u_row_dist_scan (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sof(in_sof), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [15:0] px [W], input string tag);
    int fd[W]; int fl[W]; int rd[W]; int rl[W];
    int d; int l;
    d = W + H; l = 0;
    for (int i = 0; i < W; i++) begin
      if (px[i] != BG) begin d = 0; l = px[i] & 15; end
      else if (d < 4095) d++;
      fd[i] = d; fl[i] = l;
    end
    d = W + H; l = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (px[i] != BG) begin d = 0; l = px[i] & 15; end
      else if (d < 4095) d++;
      rd[i] = d; rl[i] = l;
    end
    for (int i = 0; i < W; i++) begin
      if (rd[i] < fd[i]) exp_q.push_back(16'((rl[i] << 12) | rd[i]));
      else               exp_q.push_back(16'((fl[i] << 12) | fd[i]));
      last_q.push_back(i == W - 1);
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [15:0] px [W], input int n, input string tag);
    if (n == W) model(px, tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_pix   = px[k];
      in_sof   = (k == 0);
      if (k % 5 == 3) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      seed = seed * 1103515245 + 12345;
      out_ready = (seed[17:16] != 2'b00);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected output", out_data, 0);
        end else begin
          logic [15:0] e; bit el; string t;
          e = exp_q.pop_front(); el = last_q.pop_front(); t = tag_q.pop_front();
          check(out_data == e, {t, " R4 word"}, out_data, e);
          check(out_last == el, "R7 last flag", out_last, el);
        end
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] px [W];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R7 reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);

    foreach (px[i]) px[i] = BG;
    px[5] = 16'h0003;
    send(px, W, "R2 lone feature");

    foreach (px[i]) px[i] = BG;
    px[0] = 16'h0001; px[15] = 16'h0002;
    send(px, W, "R3 both ends");

    foreach (px[i]) px[i] = BG;
    px[2] = 16'h0004; px[6] = 16'h0009;
    send(px, W, "R3 tie keeps left");

    foreach (px[i]) px[i] = BG;
    send(px, W, "R5 R6 empty row saturates");

    foreach (px[i]) px[i] = BG;
    px[1] = 16'h7ABC; px[8] = 16'hFFFE; px[13] = 16'h0000;
    send(px, W, "R1 decode");

    foreach (px[i]) px[i] = 16'h0005;
    send(px, 5, "R8 partial");
    foreach (px[i]) px[i] = BG;
    px[10] = 16'h0006;
    send(px, W, "R8 restart");

    foreach (px[i]) px[i] = 16'(i);
    send(px, W, "R4 dense");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(in_ready && !out_valid, "R9 idle after rows", {in_ready, out_valid}, 2);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule